// File: doc/BRIEF.md
# CPU Bus Hold Arbiter

This block decides who drives a shared local CPU bus: the host CPU or one of several other bus masters, such as a bridge or a DMA engine. The CPU side uses a hold / hold-acknowledge handshake. The arbiter gives the bus to the CPU by lowering `cpu_hold`. It takes the bus back by raising `cpu_hold` and then waiting for `cpu_hlda`. Every other master uses a plain request/grant pair. Everything runs on one clock shared by the CPU side and the bridge side.

The arbiter follows bus activity through the address strobe and the ready line. It never hands the bus from one owner to another while a cycle is open. When a snoop hits a modified line, the CPU raises `cpu_hitm` and writes the line back before it gives up the bus. The arbiter waits for hit-modified to drop before it issues any master grant. A master keeps its grant for as long as it holds its request.

Two parameters set the fixed priority:
- One sets the direction of priority among the masters.
- The other says whether a CPU request outranks them. By default the CPU ranks lowest.

None of the pins carries a data stream. All pins are plain level-sensitive control signals, so there is no valid/ready back-pressure at this block's edge.

Top module: `cpu_bus_hold_arbiter`

## Requirements
- R1: While reset is active and on the first cycle after it, `cpu_hold` is 1 and `mst_gnt` is all zeros.
- R2: The CPU is given the bus by driving `cpu_hold` low. This happens on the clock edge that samples `cpu_breq`=1, no winning master request, an idle bus and `cpu_hitm`=0.
- R3: The bus counts as busy from the cycle `cpu_ads`=1 is sampled through the cycle `cpu_rdy`=1 is sampled. While the bus is busy, `cpu_hold` is not released.
- R4: When the CPU owns the bus and a master request wins priority, `cpu_hold` goes to 1 on the next edge.
- R5: A master grant is issued only on an edge where `cpu_hlda`=1 is sampled while `cpu_hold` is 1 and the bus is idle. The grant is visible right after that edge.
- R6: While `cpu_hitm`=1 no grant is issued. The grant follows on the first edge that samples `cpu_hitm`=0 with the other conditions met.
- R7: A granted master keeps its grant while its request stays 1, even if a higher-priority master starts requesting. The grant clears on the edge that samples its request at 0.
- R8: With the default `LOW_INDEX_WINS`=1, the lowest-numbered requesting master wins. With `LOW_INDEX_WINS`=0, the highest-numbered one wins.
- R9: At most one bit of `mst_gnt` is 1 at any time, and any grant implies `cpu_hold`=1.
- R10: With `CPU_OVER_MST`=1, a CPU request beats all master requests. Master requests win only once `cpu_breq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_breq | input | 1 | CPU wants the bus |
| cpu_hlda | input | 1 | CPU has released the bus in answer to hold |
| cpu_ads | input | 1 | Address strobe: a bus cycle starts |
| cpu_rdy | input | 1 | Ready: the current bus cycle ends |
| cpu_hitm | input | 1 | Snoop hit a modified line; write-back in progress |
| mst_req | input | N_MST | Per-master bus request |
| cpu_hold | output | 1 | Hold request to the CPU (low = CPU may own the bus) |
| mst_gnt | output | N_MST | Per-master grant, one-hot or zero |

## Verification
The main instance is built with three masters, low-index priority and the CPU ranked lowest. This setting covers the following:
- hand-over from the CPU to a master and back;
- deferral on an open cycle and on hit-modified;
- a higher-priority request arriving while a lower one holds the grant.

A second instance uses `LOW_INDEX_WINS`=0 and `CPU_OVER_MST`=1. It is driven by the same pins and is only checked in its own scenario. That scenario shows the reversed master order and a CPU request blocking pending masters.

// File: rtl/cbha_pkg.sv
package cbha_pkg;
  typedef enum logic [1:0] {
    ARB_HOLD = 2'd0,
    ARB_CPU  = 2'd1,
    ARB_MST  = 2'd2
  } arb_state_e;
endpackage

// File: rtl/bus_cycle_tracker.sv
module bus_cycle_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_start,
  input  logic cycle_end,
  output logic busy
);
  logic open_q;

  always_ff @(posedge clk) begin
    if (!rst_n) open_q <= 1'b0;
    else        open_q <= (open_q | cycle_start) & ~cycle_end;
  end

  assign busy = open_q | cycle_start;

  p_end_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cycle_end && !cycle_start) |=> !open_q || cycle_start);
endmodule

// File: rtl/mst_pick.sv
module mst_pick #(
  parameter int N_MST          = 3,
  parameter bit LOW_INDEX_WINS = 1'b1,
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1
) (
  input  logic [N_MST-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N_MST-1:0] onehot
);
  assign any = |req;

  generate
    if (LOW_INDEX_WINS) begin : g_low
      always_comb begin
        idx = '0;
        for (int i = N_MST - 1; i >= 0; i--) begin
          if (req[i]) idx = IDX_W'(i);
        end
      end
    end else begin : g_high
      always_comb begin
        idx = '0;
        for (int i = 0; i < N_MST; i++) begin
          if (req[i]) idx = IDX_W'(i);
        end
      end
    end
  endgenerate

  always_comb begin
    onehot = '0;
    if (any) onehot[idx] = 1'b1;
  end
endmodule

// File: rtl/cpu_bus_hold_arbiter.sv
module cpu_bus_hold_arbiter #(
  parameter int N_MST          = 3,
  parameter bit LOW_INDEX_WINS = 1'b1,
  parameter bit CPU_OVER_MST   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_breq,
  input  logic             cpu_hlda,
  input  logic             cpu_ads,
  input  logic             cpu_rdy,
  input  logic             cpu_hitm,
  input  logic [N_MST-1:0] mst_req,
  output logic             cpu_hold,
  output logic [N_MST-1:0] mst_gnt
);
  import cbha_pkg::*;
  localparam int IDX_W = (N_MST > 1) ? $clog2(N_MST) : 1;

  logic             bus_busy;
  logic             req_any;
  logic [IDX_W-1:0] pick_idx;
  logic [N_MST-1:0] pick_oh;
  logic             mst_wins;

  arb_state_e       st_q, st_d;
  logic [IDX_W-1:0] own_q, own_d;
  logic             hold_q, hold_d;
  logic [N_MST-1:0] gnt_q, gnt_d;

  bus_cycle_tracker u_track (
    .clk(clk), .rst_n(rst_n),
    .cycle_start(cpu_ads), .cycle_end(cpu_rdy), .busy(bus_busy)
  );

  mst_pick #(.N_MST(N_MST), .LOW_INDEX_WINS(LOW_INDEX_WINS)) u_pick (
    .req(mst_req), .any(req_any), .idx(pick_idx), .onehot(pick_oh)
  );

  generate
    if (CPU_OVER_MST) begin : g_cpu_top
      assign mst_wins = req_any & ~cpu_breq;
    end else begin : g_cpu_low
      assign mst_wins = req_any;
    end
  endgenerate

  always_comb begin
    st_d   = st_q;
    own_d  = own_q;
    hold_d = hold_q;
    gnt_d  = gnt_q;
    unique case (st_q)
      ARB_HOLD: begin
        hold_d = 1'b1;
        if (mst_wins && cpu_hlda && !cpu_hitm && !bus_busy) begin
          st_d  = ARB_MST;
          own_d = pick_idx;
          gnt_d = pick_oh;
        end else if (!mst_wins && cpu_breq && !cpu_hitm && !bus_busy) begin
          st_d   = ARB_CPU;
          hold_d = 1'b0;
        end
      end
      ARB_CPU: begin
        if (mst_wins) begin
          st_d   = ARB_HOLD;
          hold_d = 1'b1;
        end
      end
      ARB_MST: begin
        if (!mst_req[own_q]) begin
          st_d  = ARB_HOLD;
          gnt_d = '0;
        end
      end
      default: begin
        st_d   = ARB_HOLD;
        hold_d = 1'b1;
        gnt_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ARB_HOLD;
      own_q  <= '0;
      hold_q <= 1'b1;
      gnt_q  <= '0;
    end else begin
      st_q   <= st_d;
      own_q  <= own_d;
      hold_q <= hold_d;
      gnt_q  <= gnt_d;
    end
  end

  assign cpu_hold = hold_q;
  assign mst_gnt  = gnt_q;

  p_gnt_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mst_gnt));
  p_gnt_under_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|mst_gnt) |-> cpu_hold);
  p_gnt_after_hlda_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|mst_gnt) |-> $past(cpu_hlda));
  p_gnt_after_hitm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|mst_gnt) |-> $past(!cpu_hitm));
  p_release_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_hold) |-> $past(!bus_busy && cpu_breq));

  generate
    for (genvar i = 0; i < N_MST; i++) begin : g_keep
      p_keep_gnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mst_gnt[i] && mst_req[i]) |=> mst_gnt[i]);
    end
  endgenerate
endmodule

// File: tb/cpu_bus_hold_arbiter_tb_top.sv
module cpu_bus_hold_arbiter_tb_top;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_breq = 0, cpu_hlda = 0, cpu_ads = 0, cpu_rdy = 0, cpu_hitm = 0;
  logic [N-1:0] mst_req = '0;
  logic cpu_hold, alt_hold;
  logic [N-1:0] mst_gnt, alt_gnt;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  cpu_bus_hold_arbiter #(.N_MST(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .cpu_breq(cpu_breq), .cpu_hlda(cpu_hlda),
    .cpu_ads(cpu_ads), .cpu_rdy(cpu_rdy), .cpu_hitm(cpu_hitm),
    .mst_req(mst_req), .cpu_hold(cpu_hold), .mst_gnt(mst_gnt)
  );

  cpu_bus_hold_arbiter #(.N_MST(N), .LOW_INDEX_WINS(1'b0), .CPU_OVER_MST(1'b1)) dut_alt (
    .clk(clk), .rst_n(rst_n), .cpu_breq(cpu_breq), .cpu_hlda(cpu_hlda),
    .cpu_ads(cpu_ads), .cpu_rdy(cpu_rdy), .cpu_hitm(cpu_hitm),
    .mst_req(mst_req), .cpu_hold(alt_hold), .mst_gnt(alt_gnt)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; cpu_breq = 0; cpu_hlda = 0; cpu_ads = 0; cpu_rdy = 0;
    cpu_hitm = 0; mst_req = '0;
    tick(); tick();
    rst_n = 1;
  endtask

  task automatic t_reset();
    rst_n = 0;
    tick();
    check("R1 hold in reset", cpu_hold, 1);
    check("R1 gnt in reset", mst_gnt, 0);
    do_reset();
    tick();
    check("R1 hold after reset", cpu_hold, 1);
    check("R1 gnt after reset", mst_gnt, 0);
  endtask

  task automatic t_cpu_grant();
    do_reset();
    cpu_breq = 1;
    tick();
    check("R2 hold dropped for cpu", cpu_hold, 0);
    check("R2 no master gnt", mst_gnt, 0);
  endtask

  task automatic t_busy_defer();
    do_reset();
    cpu_breq = 1; cpu_ads = 1;
    tick();
    check("R3 hold kept on ads", cpu_hold, 1);
    cpu_ads = 0;
    tick();
    check("R3 hold kept mid cycle", cpu_hold, 1);
    cpu_rdy = 1;
    tick();
    check("R3 hold kept on rdy", cpu_hold, 1);
    cpu_rdy = 0;
    tick();
    check("R3 hold released after rdy", cpu_hold, 0);
  endtask

  task automatic t_master_handover();
    do_reset();
    cpu_breq = 1;
    tick();
    mst_req = 3'b010;
    tick();
    check("R4 hold raised for master", cpu_hold, 1);
    check("R5 no gnt before hlda", mst_gnt, 0);
    tick();
    check("R5 still no gnt", mst_gnt, 0);
    cpu_hlda = 1;
    tick();
    check("R5 gnt after hlda", mst_gnt, 3'b010);
    cpu_ads = 1;
    tick();
    cpu_ads = 0;
    tick();
    check("R7 gnt held while req", mst_gnt, 3'b010);
    check("R9 hold with gnt", cpu_hold, 1);
    mst_req = 3'b000;
    tick();
    check("R7 gnt cleared on req drop", mst_gnt, 0);
    check("R9 hold still up", cpu_hold, 1);
    cpu_rdy = 1;
    tick();
    cpu_rdy = 0;
    tick();
    check("R2 cpu regains bus", cpu_hold, 0);
    cpu_hlda = 0;
  endtask

  task automatic t_hitm_defer();
    do_reset();
    cpu_hlda = 1; cpu_hitm = 1; mst_req = 3'b001;
    tick();
    check("R6 no gnt during hitm", mst_gnt, 0);
    tick();
    check("R6 no gnt during hitm 2", mst_gnt, 0);
    cpu_hitm = 0;
    tick();
    check("R6 gnt after hitm drop", mst_gnt, 3'b001);
  endtask

  task automatic t_priority();
    do_reset();
    cpu_hlda = 1; mst_req = 3'b110;
    tick();
    check("R8 low index wins", mst_gnt, 3'b010);
    mst_req = 3'b111;
    tick();
    check("R7 no preempt", mst_gnt, 3'b010);
    mst_req = 3'b101;
    tick();
    check("R7 gnt drops", mst_gnt, 0);
    tick();
    check("R8 next low index", mst_gnt, 3'b001);
    check("R9 onehot", $countones(mst_gnt), 1);
  endtask

  task automatic t_alt_variant();
    do_reset();
    cpu_breq = 1; mst_req = 3'b011;
    tick();
    check("R10 cpu beats masters", alt_hold, 0);
    check("R10 no alt gnt", alt_gnt, 0);
    cpu_breq = 0;
    tick();
    check("R10 hold once cpu idle", alt_hold, 1);
    cpu_hlda = 1;
    tick();
    check("R8 high index wins", alt_gnt, 3'b010);
  endtask

  initial begin
    t_reset();
    t_cpu_grant();
    t_busy_defer();
    t_master_handover();
    t_hitm_defer();
    t_priority();
    t_alt_variant();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule